// File: doc/BRIEF.md
# Flash Completion Status Poller

After a host has sent a byte-program or erase command to a parallel flash, this block finds out when the operation has finished and whether it worked. It reads one status location over and over through a synchronous read port. Each read uses a request/acknowledge handshake. Then it raises a pass or a fail flag. A single start pulse gives it the location, the byte that was meant to be written, the method to use and an optional read-back check.

Two methods are offered. In completion-bit mode, the poller compares status bit 7 with bit 7 of the intended byte. In toggle mode, it watches status bit 6 to see when it stops alternating between reads. Status bit 5 is the device's error/timeout indicator. The completion bit and the error bit can change in the same read. For that reason, an error indication never fails the operation on its own: the poller first re-reads and re-tests the completion bit. A programmable poll budget stops a device that never finishes.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy, pass, fail, vfy_err and rd_req are all 0.
- R2: While a read is outstanding, rd_req stays 1 and rd_addr holds the address latched at start, until rd_ack is seen. rd_req is 0 in the cycle after each accepted acknowledge.
- R3: Completion-bit mode (start_toggle=0): a read whose bit 7 equals bit 7 of start_byte completes the operation. If verify is off, pass is set and no further read is made.
- R4: Completion-bit mode: a read whose bit 7 differs from the intended bit 7 while bit 5 is 0 causes another poll read.
- R5: Completion-bit mode: a read whose bit 7 differs while bit 5 is 1 causes exactly one further read. That read passes if bit 7 now matches and fails otherwise.
- R6: Toggle mode (start_toggle=1): the first read only sets a bit-6 reference. A later poll read with bit 5 = 0 completes the operation if its bit 6 equals the previous read's bit 6, and otherwise causes another poll read.
- R7: Toggle mode: a poll read after the first that has bit 5 = 1 causes exactly two more reads. The operation passes if bit 6 is equal in those two reads and fails otherwise.
- R8: With start_verify=1, a completed poll is followed by one read of the full byte. If the byte equals start_byte, pass is set. Otherwise fail and vfy_err are both set.
- R9: Poll reads are the reads in the polling loop; re-check and verify reads are not counted. If poll read number n would lead to another poll read and n ≥ poll_limit (latched at start), the operation ends with fail.
- R10: pass and fail are never both 1 and are both 0 while busy. They keep their value while idle and are cleared in the cycle after an accepted start.
- R11: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| start_addr | input | AW | Status location to poll |
| start_byte | input | 8 | Byte that was intended to be written |
| start_toggle | input | 1 | 1 selects toggle mode, 0 selects completion-bit mode |
| start_verify | input | 1 | 1 requests a full-byte read-back after completion |
| poll_limit | input | CW | Maximum number of poll reads |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid with it |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Operation being judged |
| pass | output | 1 | Operation judged successful |
| fail | output | 1 | Operation judged failed |
| vfy_err | output | 1 | Failure came from the read-back compare |

## Verification
The bench builds status sequences aimed at the re-check paths. It sends an error bit together with a completion bit that matches on the next read, and one that never matches. A design that failed on the first error indication, or that skipped the extra read, would report fail or the wrong read count. In toggle mode, it sets the error bit while bit 6 is still alternating, then lets bit 6 settle or keeps it moving across the two extra reads. It also sets an intended byte whose bit 7 is 0, which catches a poller that tests for 1 instead of comparing. The bench uses poll budgets that expire in both modes, runs a read-back that differs in one bit, and sends a start pulse in the middle of an operation, which a design that does not ignore it would restart.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DONE_B  = 7;
  localparam int unsigned TOG_B   = 6;
  localparam int unsigned ERR_B   = 5;

  typedef enum logic [2:0] {
    PH_DP_POLL,
    PH_DP_RC,
    PH_TG_REF,
    PH_TG_POLL,
    PH_TG_RC1,
    PH_TG_RC2,
    PH_VFY
  } phase_t;

  typedef enum logic [2:0] {
    V_CONT,
    V_STEP,
    V_DONE,
    V_FAIL,
    V_VFAIL
  } verdict_t;
endpackage

// File: rtl/fsp_judge.sv
module fsp_judge
  import fsp_pkg::*;
(
  input  phase_t            phase,
  input  logic [BYTE_W-1:0] rdat,
  input  logic [BYTE_W-1:0] want,
  input  logic              prev_tog,
  input  logic              vfy_en,
  output verdict_t          verdict,
  output phase_t            nxt
);
  logic match7, err5, same6, ok;

  assign match7 = (rdat[DONE_B] == want[DONE_B]);
  assign err5   = rdat[ERR_B];
  assign same6  = (rdat[TOG_B] == prev_tog);

  always_comb begin
    nxt     = phase;
    verdict = V_CONT;
    ok      = 1'b0;
    case (phase)
      PH_DP_POLL: begin
        if (match7)    ok = 1'b1;
        else if (err5) begin verdict = V_STEP; nxt = PH_DP_RC; end
        else           verdict = V_CONT;
      end
      PH_DP_RC: begin
        if (match7) ok = 1'b1;
        else        verdict = V_FAIL;
      end
      PH_TG_REF: begin
        verdict = V_CONT;
        nxt     = PH_TG_POLL;
      end
      PH_TG_POLL: begin
        if (err5)       begin verdict = V_STEP; nxt = PH_TG_RC1; end
        else if (same6) ok = 1'b1;
        else            verdict = V_CONT;
      end
      PH_TG_RC1: begin
        verdict = V_STEP;
        nxt     = PH_TG_RC2;
      end
      PH_TG_RC2: begin
        if (same6) ok = 1'b1;
        else       verdict = V_FAIL;
      end
      PH_VFY: begin
        verdict = (rdat == want) ? V_DONE : V_VFAIL;
      end
      default: verdict = V_FAIL;
    endcase
    if (ok) begin
      if (vfy_en && phase != PH_VFY) begin
        verdict = V_STEP;
        nxt     = PH_VFY;
      end else begin
        verdict = V_DONE;
      end
    end
  end
endmodule

// File: rtl/fsp_read_port.sv
module fsp_read_port (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_nxt,
  input  logic rd_ack,
  output logic rd_req
);
  logic req_d;

  always_comb begin
    req_d = busy_nxt && !(rd_req && rd_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_req <= 1'b0;
    else        rd_req <= req_d;
  end

  // R2: request held until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);
  // R2: one idle cycle after every acknowledge
  a_r2_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req);
endmodule

// File: rtl/fsp_poll_budget.sv
module fsp_poll_budget #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   this_read;
  logic          cnt_en;

  assign this_read = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign last      = (this_read >= {1'b0, limit});
  assign cnt_en    = clr || (tick && cnt_q != {CW{1'b1}});

  always_comb begin
    cnt_d = clr ? '0 : this_read[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: counter restarts from zero on every accepted start
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [BYTE_W-1:0] start_byte,
  input  logic              start_toggle,
  input  logic              start_verify,
  input  logic [CW-1:0]     poll_limit,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic              vfy_err
);
  phase_t            phase_q, phase_d, jnxt;
  verdict_t          verd;
  logic              busy_d, pass_d, fail_d, vfy_d;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] want_q;
  logic              vfy_en_q, prev_q;
  logic [CW-1:0]     limit_q;
  logic              take, ack_v, poll_tick, last;

  assign take      = start && !busy;
  assign ack_v     = busy && rd_ack && rd_req;
  assign poll_tick = ack_v && (phase_q == PH_DP_POLL || phase_q == PH_TG_REF ||
                               phase_q == PH_TG_POLL);
  assign rd_addr   = addr_q;

  fsp_judge u_judge (
    .phase    (phase_q),
    .rdat     (rd_data),
    .want     (want_q),
    .prev_tog (prev_q),
    .vfy_en   (vfy_en_q),
    .verdict  (verd),
    .nxt      (jnxt)
  );

  fsp_poll_budget #(.CW(CW)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (take),
    .tick  (poll_tick),
    .limit (limit_q),
    .last  (last)
  );

  fsp_read_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_nxt (busy_d),
    .rd_ack   (rd_ack),
    .rd_req   (rd_req)
  );

  always_comb begin
    busy_d  = busy;
    pass_d  = pass;
    fail_d  = fail;
    vfy_d   = vfy_err;
    phase_d = phase_q;
    if (take) begin
      busy_d  = 1'b1;
      pass_d  = 1'b0;
      fail_d  = 1'b0;
      vfy_d   = 1'b0;
      phase_d = start_toggle ? PH_TG_REF : PH_DP_POLL;
    end else if (ack_v) begin
      case (verd)
        V_CONT: begin
          if (last) begin busy_d = 1'b0; fail_d = 1'b1; end
          else      phase_d = jnxt;
        end
        V_STEP:  phase_d = jnxt;
        V_DONE:  begin busy_d = 1'b0; pass_d = 1'b1; end
        V_FAIL:  begin busy_d = 1'b0; fail_d = 1'b1; end
        default: begin busy_d = 1'b0; fail_d = 1'b1; vfy_d = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      vfy_err <= 1'b0;
      phase_q <= PH_DP_POLL;
    end else begin
      busy    <= busy_d;
      pass    <= pass_d;
      fail    <= fail_d;
      vfy_err <= vfy_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      want_q   <= '0;
      vfy_en_q <= 1'b0;
      limit_q  <= '0;
    end else if (take) begin
      addr_q   <= start_addr;
      want_q   <= start_byte;
      vfy_en_q <= start_verify;
      limit_q  <= poll_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (ack_v) prev_q <= rd_data[TOG_B];
  end

  // R10: flags exclusive and low while busy
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pass && !fail);
  // R10: flags hold while idle without a start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && $stable(pass) && $stable(fail));
  // R11: start while busy changes nothing without an acknowledge
  a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_ack |=> busy && $stable(rd_addr));
  // R5: the single re-check read ends the data poll
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_ack && rd_req && phase_q == PH_DP_RC |=> !busy || phase_q == PH_VFY);
  // R9: expired budget forces fail
  a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ack_v && !take && verd == V_CONT && last |=> fail && !busy);
  // R8: verify error only alongside fail
  a_r8_vfy_fail: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_err |-> fail);
endmodule

// File: tb/sim_flash_status_poller.sv
module sim_flash_status_poller;
  localparam int AW  = 16;
  localparam int CW  = 16;
  localparam int LAT = 3;

  logic          clk, rst_n;
  logic          start, start_toggle, start_verify;
  logic [AW-1:0] start_addr;
  logic [7:0]    start_byte;
  logic [CW-1:0] poll_limit;
  logic          rd_req, rd_ack;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy, pass, fail, vfy_err;

  int total = 0;
  int bad   = 0;
  int nreads = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [7:0] resp [0:7];
  int nresp = 1;
  int ridx = 0;
  int cnt = 0;

  typedef struct {
    bit    p;
    bit    f;
    bit    v;
    int    n;
    string tag;
  } exp_t;
  exp_t sbq[$];
  logic busy_seen = 1'b0;

  flash_status_poller #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_byte(start_byte), .start_toggle(start_toggle),
    .start_verify(start_verify), .poll_limit(poll_limit),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .pass(pass), .fail(fail), .vfy_err(vfy_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // flash model: fixed latency, scripted status bytes
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
      cnt = 0;
    end else begin
      rd_ack <= 1'b0;
      if (rd_req && !rd_ack) begin
        if (cnt == LAT - 1) begin
          cnt = 0;
          rd_ack  <= 1'b1;
          rd_data <= resp[ridx];
          if (ridx < nresp - 1) ridx = ridx + 1;
          nreads = nreads + 1;
          chk(rd_addr == cur_addr, "R2", "read address", int'(rd_addr), int'(cur_addr));
        end else begin
          cnt = cnt + 1;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (busy_seen && !busy) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R10", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(pass == e.p,    e.tag, "pass",    int'(pass),    int'(e.p));
        chk(fail == e.f,    e.tag, "fail",    int'(fail),    int'(e.f));
        chk(vfy_err == e.v, e.tag, "vfy_err", int'(vfy_err), int'(e.v));
        chk(nreads == e.n,  e.tag, "reads",   nreads,        e.n);
      end
    end
    busy_seen = busy;
  end

  task automatic set_resp(input logic [63:0] v, input int n);
    for (int i = 0; i < 8; i++) resp[i] = v[63-8*i -: 8];
    nresp = n;
  endtask

  task automatic go(input bit tog, input bit vfy, input logic [7:0] want,
                    input int lim, input bit ep, input bit ef, input bit ev,
                    input int en, input string tag, input bit dbl);
    exp_t e;
    e.p = ep; e.f = ef; e.v = ev; e.n = en; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    ridx = 0;
    nreads = 0;
    cur_addr = cur_addr + 16'h0123;
    start_addr = cur_addr;
    start_byte = want;
    start_toggle = tog;
    start_verify = vfy;
    poll_limit = CW'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && !fail, "R10", "flags cleared on start",
        int'({busy, pass, fail}), 4);
    if (dbl) begin
      @(negedge clk);
      start_addr = 16'hBEEF;
      start_toggle = !tog;
      start_byte = ~want;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R11", "busy after mid-run start", int'(busy), 1);
    end
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(pass == ep && fail == ef, "R10", "flags held while idle",
        int'({pass, fail}), int'({ep, ef}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    start_addr = '0;
    start_byte = '0;
    start_toggle = 1'b0;
    start_verify = 1'b0;
    poll_limit = '0;
    rd_data = '0;
    set_resp(64'h0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pass && !fail && !vfy_err && !rd_req, "R1", "reset state",
        int'({busy, pass, fail, vfy_err, rd_req}), 0);

    // R3: immediate match, single read
    set_resp({8'h80, 56'h0}, 1);
    go(0, 0, 8'hA5, 100, 1, 0, 0, 1, "R3", 0);
    // R4: two busy reads then match
    set_resp({8'h00, 8'h00, 8'h80, 40'h0}, 3);
    go(0, 0, 8'hA5, 100, 1, 0, 0, 3, "R4", 0);
    // R3/R4: intended bit 7 is 0
    set_resp({8'h80, 8'h00, 48'h0}, 2);
    go(0, 0, 8'h3C, 100, 1, 0, 0, 2, "R3", 0);
    // R5: error then match on re-check
    set_resp({8'h20, 8'h80, 48'h0}, 2);
    go(0, 0, 8'hA5, 100, 1, 0, 0, 2, "R5", 0);
    // R5: error then still mismatched -> fail after exactly one extra read
    set_resp({8'h20, 8'h20, 8'h80, 40'h0}, 3);
    go(0, 0, 8'hA5, 100, 0, 1, 0, 2, "R5", 0);
    // R9: completion-bit budget
    set_resp(64'h0, 1);
    go(0, 0, 8'hA5, 4, 0, 1, 0, 4, "R9", 0);
    // R6 + R11: toggles twice then settles, start pulse mid-run
    set_resp({8'h00, 8'h40, 8'h00, 8'h00, 32'h0}, 4);
    go(1, 0, 8'hA5, 100, 1, 0, 0, 4, "R6", 1);
    // R7: error while toggling, then settled
    set_resp({8'h00, 8'h60, 8'h40, 8'h40, 32'h0}, 4);
    go(1, 0, 8'hA5, 100, 1, 0, 0, 4, "R7", 0);
    // R7: error while toggling, still toggling
    set_resp({8'h00, 8'h60, 8'h00, 8'h40, 8'h40, 24'h0}, 5);
    go(1, 0, 8'hA5, 100, 0, 1, 0, 4, "R7", 0);
    // R8: verify good
    set_resp({8'h80, 8'hA5, 48'h0}, 2);
    go(0, 1, 8'hA5, 100, 1, 0, 0, 2, "R8", 0);
    // R8: verify one bit off
    set_resp({8'h80, 8'hA4, 48'h0}, 2);
    go(0, 1, 8'hA5, 100, 0, 1, 1, 2, "R8", 0);
    // R8: toggle mode then verify
    set_resp({8'h00, 8'h00, 8'hA5, 40'h0}, 3);
    go(1, 1, 8'hA5, 100, 1, 0, 0, 3, "R8", 0);
    // R9: toggle budget
    set_resp({8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40}, 8);
    go(1, 0, 8'hA5, 3, 0, 1, 0, 3, "R9", 0);

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R10", "scoreboard drained", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule